// File: doc/BRIEF.md
# Cartridge Register and Bank Controller

This block is the register file and memory-map controller of a game cartridge on an 8-bit CPU bus with a separate video bus. CPU writes to the upper half of the address space are decoded through a sparse mask into a handful of registers. One register holds the lower program bank. Four registers hold the character banks. One control byte packs the nametable mirroring mode together with two feature enables. Eight register slots are passed on as write strobes to two external sound channels. CPU reads in a small window return either a fixed status byte that carries a configuration switch, or the readback of one of the sound channels.

From these registers the block produces, one clock after each request, the program ROM address, the character ROM address, the nametable page selected by the current mirroring mode, and the work-RAM select and write enable. The sound channels themselves sit outside the block. The block only strobes them and forwards their readback.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write is decoded as a register write only when the address lies in 0x8000–0xBFFF. The register index is address bits 3:0, which is the address ANDed with 0x800F, so every other address bit is ignored. Writes at 0xC000 and above and writes below 0x8000 leave every register unchanged.
- R2: A register write with index 0–3 gives a one-cycle pulse on `snd_wr[0]`, and an index of 4–7 gives a pulse on `snd_wr[1]`. In the same cycle `snd_reg` carries address bits 1:0 and `snd_wdata` carries the written byte. Every other index leaves `snd_wr` at zero.
- R3: Index 0xA is the control register. Data bits 1:0 give the mirroring code (0 vertical, 1 horizontal, 2 single page A, 3 single page B) and drive `mirror_mode`. Bit 2 drives `ext_attr_en`. Bit 3 allows work-RAM writes.
- R4: `nt_page` equals `ppu_addr[10]` for code 0, `ppu_addr[11]` for code 1, 0 for code 2 and 1 for code 3.
- R5: Index 0xB loads the lower program bank from data bits 3:0. `prg_addr` is {bank, cpu_addr[13:0]}. The bank is the loaded one when `cpu_addr[14]` is 0, and 15 (the last bank) when it is 1.
- R6: Indices 0xC–0xF load character banks 0–3 from data bits 3:0. `chr_addr` is {bank[ppu_addr[12:11]], ppu_addr[10:0]}, and `chr_sel` is the inverse of `ppu_addr[13]`.
- R7: A read in 0x4800–0x5FFF is decoded by the address ANDed with 0x5800. A result of 0x4800 returns 0x64 with bit 7 set to `cfg_switch`. A result of 0x5000 returns `snd0_rdata`, and 0x5800 returns `snd1_rdata`.
- R8: `cpu_rdata` is zero for reads at any other address and whenever `cpu_rd` is low.
- R9: `wram_sel` is high for any read or write in 0x6000–0x7FFF. `wram_we` is high only for a write there while the control write-allow bit is set.
- R10: After reset the lower program bank is 1, the character banks are 0 and the control register is 0. All strobes and `cpu_rdata` are also zero.
- R11: Every output is registered. It reflects the inputs and register state of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write request, one cycle per access |
| cpu_rd | input | 1 | CPU read request, one cycle per access |
| cpu_rdata | output | 8 | Registered read data |
| snd0_rdata | input | 8 | Readback from sound channel 0 |
| snd1_rdata | input | 8 | Readback from sound channel 1 |
| cfg_switch | input | 1 | Configuration switch reported in the status byte |
| ppu_addr | input | 14 | Video bus address |
| prg_addr | output | 18 | Program ROM address |
| chr_addr | output | 15 | Character ROM address |
| chr_sel | output | 1 | Video access is in pattern space |
| nt_page | output | 1 | Nametable page chosen by mirroring |
| mirror_mode | output | 2 | Current mirroring code |
| ext_attr_en | output | 1 | Extended attribute enable bit |
| wram_sel | output | 1 | Work-RAM access |
| wram_we | output | 1 | Work-RAM write enable |
| snd_wr | output | 2 | Per-channel sound register write strobes |
| snd_reg | output | 2 | Sound register select |
| snd_wdata | output | 8 | Sound register write data |

## Verification
A bank register holding the wrong value shows on the very next address cycle that uses it. `prg_addr` bits 17:14 expose the lower bank and `chr_addr` bits 14:11 expose the bank of the window the video address selects, so every register can be read back through ordinary fetches one cycle after it is written. A bad control byte appears at once on `mirror_mode` and `ext_attr_en`. It also appears on `nt_page` at the next video address and on `wram_we` at the next work-RAM write. Decode faults are exposed by writing aliases that differ only in the masked-off address bits, and by writing to addresses above the register window, then reading the mapped addresses back.

// File: rtl/cart_pkg.sv
package cart_pkg;
  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  localparam logic [3:0] IDX_CTRL = 4'hA;
  localparam logic [3:0] IDX_PRG  = 4'hB;
  localparam logic [3:0] IDX_CHR0 = 4'hC;

  localparam logic [6:0] STATUS_FIXED = 7'h64;

  localparam logic [15:0] RD_LO   = 16'h4800;
  localparam logic [15:0] RD_HI   = 16'h5FFF;
  localparam logic [15:0] RD_MASK = 16'h5800;
  localparam logic [15:0] RD_STAT = 16'h4800;
  localparam logic [15:0] RD_SND0 = 16'h5000;
  localparam logic [15:0] RD_SND1 = 16'h5800;
endpackage

// File: rtl/cart_reg_file.sv
module cart_reg_file #(
  parameter int DW         = 8,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 4,
  parameter int CHR_WIN    = 4,
  parameter int SND_CH     = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cpu_wr,
  input  logic [1:0]                            addr_top,
  input  logic [3:0]                            addr_idx,
  input  logic [DW-1:0]                         cpu_wdata,
  output logic [PRG_BANK_W-1:0]                 prg_bank,
  output logic [CHR_WIN-1:0][CHR_BANK_W-1:0]    chr_bank,
  output cart_pkg::mirror_e                     mirror,
  output logic                                  ext_en,
  output logic                                  wram_en,
  output logic [SND_CH-1:0]                     snd_wr,
  output logic [1:0]                            snd_reg,
  output logic [DW-1:0]                         snd_wdata
);
  import cart_pkg::*;

  localparam logic [PRG_BANK_W-1:0] PRG_RESET = PRG_BANK_W'(1);

  logic reg_win;
  assign reg_win = cpu_wr && (addr_top == 2'b10);

  // program bank for the lower window
  always_ff @(posedge clk) begin
    if (rst)
      prg_bank <= PRG_RESET;
    else if (reg_win && addr_idx == IDX_PRG)
      prg_bank <= cpu_wdata[PRG_BANK_W-1:0];
  end

  // control byte
  always_ff @(posedge clk) begin
    if (rst) begin
      mirror  <= MIR_VERT;
      ext_en  <= 1'b0;
      wram_en <= 1'b0;
    end else if (reg_win && addr_idx == IDX_CTRL) begin
      mirror  <= mirror_e'(cpu_wdata[1:0]);
      ext_en  <= cpu_wdata[2];
      wram_en <= cpu_wdata[3];
    end
  end

  // character bank per window
  for (genvar w = 0; w < CHR_WIN; w++) begin : g_chr
    logic hit;
    assign hit = reg_win && (addr_idx == 4'(IDX_CHR0 + 4'(w)));
    always_ff @(posedge clk) begin
      if (rst)
        chr_bank[w] <= '0;
      else if (hit)
        chr_bank[w] <= cpu_wdata[CHR_BANK_W-1:0];
    end
  end

  // sound channel strobes: four slots per channel from index 0 upward
  logic [SND_CH-1:0] snd_hit;
  for (genvar c = 0; c < SND_CH; c++) begin : g_snd
    assign snd_hit[c] = reg_win && (addr_idx[3:2] == 2'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snd_wr    <= '0;
      snd_reg   <= '0;
      snd_wdata <= '0;
    end else begin
      snd_wr    <= snd_hit;
      snd_reg   <= addr_idx[1:0];
      snd_wdata <= cpu_wdata;
    end
  end

  p_upper_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && addr_top == 2'b11) |=> ($stable(prg_bank) && $stable(chr_bank)
                                       && $stable(mirror) && $stable(wram_en)));

  p_snd_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
    (snd_wr != '0) |-> ($past(cpu_wr) && $past(addr_top) == 2'b10));

  p_snd_single_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(snd_wr));
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map #(
  parameter int CPU_AW     = 16,
  parameter int PPU_AW     = 14,
  parameter int PRG_BANK_W = 4,
  parameter int PRG_OFF_W  = 14,
  parameter int CHR_BANK_W = 4,
  parameter int CHR_OFF_W  = 11,
  parameter int CHR_WIN    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [CPU_AW-1:0]                     cpu_addr,
  input  logic                                  cpu_wr,
  input  logic                                  cpu_rd,
  input  logic [PPU_AW-1:0]                     ppu_addr,
  input  logic [PRG_BANK_W-1:0]                 prg_bank,
  input  logic [CHR_WIN-1:0][CHR_BANK_W-1:0]    chr_bank,
  input  cart_pkg::mirror_e                     mirror,
  input  logic                                  wram_en,
  output logic [PRG_BANK_W+PRG_OFF_W-1:0]       prg_addr,
  output logic [CHR_BANK_W+CHR_OFF_W-1:0]       chr_addr,
  output logic                                  chr_sel,
  output logic                                  nt_page,
  output logic                                  wram_sel,
  output logic                                  wram_we
);
  import cart_pkg::*;

  localparam int WIN_W = $clog2(CHR_WIN);
  localparam int PRG_W = PRG_BANK_W + PRG_OFF_W;
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

  logic [PRG_BANK_W-1:0] prg_pick;
  logic [WIN_W-1:0]      win;
  logic                  nt_next;
  logic                  wram_hit;

  assign prg_pick = cpu_addr[PRG_OFF_W] ? LAST_BANK : prg_bank;
  assign win      = ppu_addr[CHR_OFF_W +: WIN_W];
  assign wram_hit = (cpu_addr[CPU_AW-1 -: 3] == 3'b011);

  always_comb begin
    unique case (mirror)
      MIR_VERT:  nt_next = ppu_addr[10];
      MIR_HORZ:  nt_next = ppu_addr[11];
      MIR_ONE_A: nt_next = 1'b0;
      default:   nt_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      chr_addr <= '0;
      chr_sel  <= 1'b0;
      nt_page  <= 1'b0;
      wram_sel <= 1'b0;
      wram_we  <= 1'b0;
    end else begin
      prg_addr <= {prg_pick, cpu_addr[PRG_OFF_W-1:0]};
      chr_addr <= {chr_bank[win], ppu_addr[CHR_OFF_W-1:0]};
      chr_sel  <= ~ppu_addr[PPU_AW-1];
      nt_page  <= nt_next;
      wram_sel <= wram_hit && (cpu_rd || cpu_wr);
      wram_we  <= wram_hit && cpu_wr && wram_en;
    end
  end

  p_fixed_top_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[PRG_OFF_W] |=> (prg_addr[PRG_W-1 -: PRG_BANK_W] == LAST_BANK));

  p_wram_gate_r9: assert property (@(posedge clk) disable iff (rst)
    wram_we |-> ($past(wram_en) && $past(cpu_wr)));

  p_single_page_r4: assert property (@(posedge clk) disable iff (rst)
    (mirror == MIR_ONE_B && $stable(mirror)) |=> nt_page);
endmodule

// File: rtl/cart_read_mux.sv
module cart_read_mux #(
  parameter int CPU_AW = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cfg_switch,
  input  logic [DW-1:0]     snd0_rdata,
  input  logic [DW-1:0]     snd1_rdata,
  output logic [DW-1:0]     cpu_rdata
);
  import cart_pkg::*;

  logic              in_win;
  logic [CPU_AW-1:0] sel;
  logic [DW-1:0]     rd_next;

  assign in_win = (cpu_addr >= RD_LO) && (cpu_addr <= RD_HI);
  assign sel    = cpu_addr & RD_MASK;

  always_comb begin
    rd_next = '0;
    if (cpu_rd && in_win) begin
      if (sel == RD_STAT)      rd_next = {cfg_switch, STATUS_FIXED};
      else if (sel == RD_SND0) rd_next = snd0_rdata;
      else if (sel == RD_SND1) rd_next = snd1_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_next;
  end

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == '0));

  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:11] == 5'b01001) |=> (cpu_rdata[6:0] == STATUS_FIXED));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int CPU_AW     = 16,
  parameter int DW         = 8,
  parameter int PPU_AW     = 14,
  parameter int PRG_BANK_W = 4,
  parameter int PRG_OFF_W  = 14,
  parameter int CHR_BANK_W = 4,
  parameter int CHR_OFF_W  = 11,
  parameter int CHR_WIN    = 4,
  parameter int SND_CH     = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [CPU_AW-1:0]                 cpu_addr,
  input  logic [DW-1:0]                     cpu_wdata,
  input  logic                              cpu_wr,
  input  logic                              cpu_rd,
  output logic [DW-1:0]                     cpu_rdata,
  input  logic [DW-1:0]                     snd0_rdata,
  input  logic [DW-1:0]                     snd1_rdata,
  input  logic                              cfg_switch,
  input  logic [PPU_AW-1:0]                 ppu_addr,
  output logic [PRG_BANK_W+PRG_OFF_W-1:0]   prg_addr,
  output logic [CHR_BANK_W+CHR_OFF_W-1:0]   chr_addr,
  output logic                              chr_sel,
  output logic                              nt_page,
  output logic [1:0]                        mirror_mode,
  output logic                              ext_attr_en,
  output logic                              wram_sel,
  output logic                              wram_we,
  output logic [SND_CH-1:0]                 snd_wr,
  output logic [1:0]                        snd_reg,
  output logic [DW-1:0]                     snd_wdata
);
  import cart_pkg::*;

  logic [PRG_BANK_W-1:0]               prg_bank;
  logic [CHR_WIN-1:0][CHR_BANK_W-1:0]  chr_bank;
  mirror_e                             mirror;
  logic                                wram_en;

  cart_reg_file #(
    .DW(DW), .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W),
    .CHR_WIN(CHR_WIN), .SND_CH(SND_CH)
  ) regs_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr),
    .addr_top(cpu_addr[CPU_AW-1 -: 2]), .addr_idx(cpu_addr[3:0]),
    .cpu_wdata(cpu_wdata),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror),
    .ext_en(ext_attr_en), .wram_en(wram_en),
    .snd_wr(snd_wr), .snd_reg(snd_reg), .snd_wdata(snd_wdata)
  );

  cart_addr_map #(
    .CPU_AW(CPU_AW), .PPU_AW(PPU_AW), .PRG_BANK_W(PRG_BANK_W),
    .PRG_OFF_W(PRG_OFF_W), .CHR_BANK_W(CHR_BANK_W), .CHR_OFF_W(CHR_OFF_W),
    .CHR_WIN(CHR_WIN)
  ) map_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .mirror(mirror), .wram_en(wram_en),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .chr_sel(chr_sel),
    .nt_page(nt_page), .wram_sel(wram_sel), .wram_we(wram_we)
  );

  cart_read_mux #(.CPU_AW(CPU_AW), .DW(DW)) rd_i (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cfg_switch(cfg_switch), .snd0_rdata(snd0_rdata),
    .snd1_rdata(snd1_rdata), .cpu_rdata(cpu_rdata)
  );

  assign mirror_mode = mirror;

  p_rst_bank_r10: assert property (@(posedge clk)
    $past(rst) && !rst |-> (prg_bank == PRG_BANK_W'(1) && snd_wr == '0 && cpu_rdata == '0));
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [7:0]  snd0_rdata = 8'hA5;
  logic [7:0]  snd1_rdata = 8'h5A;
  logic        cfg_switch = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [17:0] prg_addr;
  logic [14:0] chr_addr;
  logic        chr_sel, nt_page, ext_attr_en, wram_sel, wram_we;
  logic [1:0]  mirror_mode, snd_wr, snd_reg;
  logic [7:0]  snd_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .snd0_rdata(snd0_rdata), .snd1_rdata(snd1_rdata), .cfg_switch(cfg_switch),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
    .chr_sel(chr_sel), .nt_page(nt_page), .mirror_mode(mirror_mode),
    .ext_attr_en(ext_attr_en), .wram_sel(wram_sel), .wram_we(wram_we),
    .snd_wr(snd_wr), .snd_reg(snd_reg), .snd_wdata(snd_wdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write: outputs registered at the covered edge are sampled on return
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic cpu_fetch(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
  endtask

  task automatic ppu_fetch(input logic [13:0] a);
    @(negedge clk);
    ppu_addr = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 rdata", cpu_rdata, 0);
    check("R10 snd_wr", snd_wr, 0);
    check("R10 mirror", mirror_mode, 0);
    check("R10 ext", ext_attr_en, 0);
    cpu_fetch(16'h8123);
    check("R10 prg bank 1", prg_addr, 18'h04123);
    ppu_fetch(14'h1FFF);
    check("R10 chr bank 0", chr_addr, 15'h07FF);
  endtask

  task automatic t_prg();
    cpu_write(16'hA7FB, 8'hF5);  // alias of index B
    cpu_fetch(16'h9ABC);
    check("R5 prg low window", prg_addr, {4'h5, 14'h1ABC});
    cpu_fetch(16'hC456);
    check("R5 prg fixed last", prg_addr, {4'hF, 14'h0456});
    check("R11 snd quiet", snd_wr, 0);
    cpu_write(16'hC00B, 8'h0A);  // above register window
    cpu_write(16'h700B, 8'h0C);  // below register window
    cpu_fetch(16'h8000);
    check("R1 upper/lower writes ignored", prg_addr, {4'h5, 14'h0000});
  endtask

  task automatic t_chr();
    cpu_write(16'h800C, 8'h03);
    cpu_write(16'h8FFD, 8'h07);
    cpu_write(16'h800E, 8'hF9);
    cpu_write(16'hB00F, 8'h0E);
    ppu_fetch(14'h0010);
    check("R6 chr win0", chr_addr, 15'h1810);
    ppu_fetch(14'h0820);
    check("R6 chr win1", chr_addr, 15'h3820);
    ppu_fetch(14'h1234);
    check("R6 chr win2", chr_addr, 15'h4A34);
    check("R6 chr_sel", chr_sel, 1);
    ppu_fetch(14'h1FFF);
    check("R6 chr win3", chr_addr, 15'h77FF);
    ppu_fetch(14'h2000);
    check("R6 chr_sel nametable", chr_sel, 0);
  endtask

  task automatic t_mirror();
    cpu_write(16'h800A, 8'h00);
    ppu_fetch(14'h2400);
    check("R4 vert 0x2400", nt_page, 1);
    ppu_fetch(14'h2800);
    check("R4 vert 0x2800", nt_page, 0);
    cpu_write(16'h800A, 8'h01);
    check("R3 mirror horiz", mirror_mode, 1);
    ppu_fetch(14'h2400);
    check("R4 horiz 0x2400", nt_page, 0);
    ppu_fetch(14'h2800);
    check("R4 horiz 0x2800", nt_page, 1);
    cpu_write(16'h800A, 8'h06);
    check("R3 mirror A", mirror_mode, 2);
    check("R3 ext on", ext_attr_en, 1);
    ppu_fetch(14'h2C00);
    check("R4 single A", nt_page, 0);
    cpu_write(16'h800A, 8'h03);
    check("R3 ext off", ext_attr_en, 0);
    ppu_fetch(14'h2000);
    check("R4 single B", nt_page, 1);
  endtask

  task automatic t_sound();
    cpu_write(16'h8002, 8'h3C);
    check("R2 ch0 strobe", snd_wr, 2'b01);
    check("R2 ch0 reg", snd_reg, 2);
    check("R2 ch0 data", snd_wdata, 8'h3C);
    @(negedge clk);
    check("R2 single pulse", snd_wr, 0);
    cpu_write(16'hB1F5, 8'h77);
    check("R2 ch1 strobe", snd_wr, 2'b10);
    check("R2 ch1 reg", snd_reg, 1);
    cpu_write(16'h8009, 8'h11);
    check("R2 index 9 no strobe", snd_wr, 0);
    cpu_write(16'hC003, 8'h11);
    check("R1 C003 no strobe", snd_wr, 0);
  endtask

  task automatic t_read();
    cfg_switch = 1'b0;
    cpu_read(16'h4800);
    check("R7 status off", cpu_rdata, 8'h64);
    cfg_switch = 1'b1;
    cpu_read(16'h4FFF);
    check("R7 status on", cpu_rdata, 8'hE4);
    cpu_read(16'h5000);
    check("R7 snd0", cpu_rdata, 8'hA5);
    cpu_read(16'h5FFF);
    check("R7 snd1", cpu_rdata, 8'h5A);
    cpu_read(16'h4000);
    check("R8 below window", cpu_rdata, 0);
    cpu_read(16'hC800);
    check("R8 alias outside window", cpu_rdata, 0);
    cpu_fetch(16'h4800);
    check("R8 no read strobe", cpu_rdata, 0);
  endtask

  task automatic t_wram();
    cpu_write(16'h800A, 8'h00);
    cpu_write(16'h6010, 8'h99);
    check("R9 we blocked", wram_we, 0);
    check("R9 sel on write", wram_sel, 1);
    cpu_write(16'h800A, 8'h08);
    cpu_write(16'h7FF0, 8'h99);
    check("R9 we allowed", wram_we, 1);
    cpu_read(16'h7FFF);
    check("R9 read sel", wram_sel, 1);
    check("R9 read no we", wram_we, 0);
    cpu_write(16'h8010, 8'h00);
    check("R9 outside no sel", wram_sel, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prg();
    t_chr();
    t_mirror();
    t_sound();
    t_read();
    t_wram();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule